// File: doc/BRIEF.md
# DDR3 Multipurpose Register Read Serializer

This block models the device side of a DDR3 read issued while the memory is in its multipurpose-register mode. In that mode a READ command does not touch the array. The block checks the command's low column-address bits, works out whether the burst is a full eight beats or chopped to four, and waits the programmed read latency. It then shifts a fixed 8-bit pattern out one bit per beat, least significant bit first.

The serial bit appears on bit 0 of every byte lane, so an x16 part carries the same bit on both lanes. A static option decides whether the other seven bits of each lane copy that bit or stay low. One beat is modelled per internal tick; each tick stands for one half-period of the memory clock. A one-tick valid strobe marks every beat.

A command that breaks the addressing rules, or that arrives before the delay-locked loop reports lock, raises a one-tick illegal flag and returns no data. A command that arrives while a read is already in flight is dropped without a flag. So is a command that arrives while the register mode is off.

Top module: `mpr_read_serializer`

## Requirements
- R1: During a burst, bit 0 of every byte lane carries the current serial bit, and all byte lanes (two when LANES=2) are identical.
- R2: During a burst, bits 7:1 of each lane equal bit 0 when `replicateDq`=1 and are 0 when `replicateDq`=0.
- R3: A full burst (8 beats) issued with `colAddr[2:0]`=000 returns PATTERN[0] in beat 0 through PATTERN[7] in beat 7.
- R4: A chopped burst lasts exactly 4 beats. With `colAddr[2]`=0 it returns PATTERN[0..3], and with `colAddr[2]`=1 it returns PATTERN[4..7], lowest index first. Every burst lasts 4 or 8 valid ticks.
- R5: With `mrOtf`=1, `colAddr[12]`=0 selects the chopped burst and `colAddr[12]`=1 the full burst. With `mrOtf`=0, `mrChop`=1 selects chopped and `mrChop`=0 selects full, whatever `colAddr[12]` holds.
- R6: `bankAddr` and `colAddr[11:3]` have no effect on the data, its timing or the illegal flag.
- R7: The command is sampled at edge E0. The first beat is valid in the tick after edge E_RL, where RL is `rdLatency`; a value of 0 is treated as 1. Beats then follow on consecutive ticks.
- R8: An accepted command is illegal if `dllLocked`=0, if `colAddr[1:0]`≠00, or if it is a full burst with `colAddr[2]`=1. An illegal command sets `illegalCmd` for the one tick after E0 and produces no valid beats.
- R9: A command is ignored, with no flag and no data, when `mprEnable`=0 or while an earlier read is still waiting or bursting.
- R10: After reset, and whenever no burst is active, `dq`=0, `dqValid`=0 and `illegalCmd`=0 except for the flag tick of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat tick clock (one tick per data half-cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | READ command strobe, one tick |
| mprEnable | input | 1 | Multipurpose-register mode is on |
| dllLocked | input | 1 | Delay-locked loop reports lock |
| colAddr | input | ADDR_W (13) | Column address; bit 12 is the active-low chop request |
| bankAddr | input | BA_W (3) | Bank address (ignored) |
| mrChop | input | 1 | Mode-register fixed chop setting |
| mrOtf | input | 1 | Mode register allows chop selection per command |
| replicateDq | input | 1 | 1: copy the serial bit onto bits 7:1; 0: drive them low |
| rdLatency | input | RL_W (4) | Read latency in ticks |
| dq | output | 8*LANES | Data lanes |
| dqValid | output | 1 | Beat valid strobe |
| illegalCmd | output | 1 | One-tick flag for a rejected command |

## Verification
The hardest situation to reach from the ports is a second command that lands while the first read is still counting down its latency. It must be dropped silently, even when it would otherwise be flagged as illegal. The stimulus issues a legal read and, one tick later, a read with a bad low address. The scoreboard then expects only the first burst and no flag. The upper half of the pattern is reachable only through a chopped burst with `colAddr[2]` set. It is reached through both the fixed mode-register setting and the per-command chop request, and an asymmetric pattern exposes any beat-order error.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  // Control sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } mprState_t;

  // Strobes handed from control to datapath
  typedef struct packed {
    logic       load;      // capture pattern aligned to startIdx
    logic       beatEn;    // a beat is on the lanes this tick; shift after it
    logic [2:0] startIdx;  // first pattern bit of the burst
  } mprStrobe_t;

endpackage

// File: rtl/mpr_ctrl.sv
module mpr_ctrl
  import mpr_pkg::*;
#(
  parameter int RL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmdValid,
  input  logic            mprEnable,
  input  logic            dllLocked,
  input  logic [2:0]      addrLow,
  input  logic            chopReqN,
  input  logic            mrChop,
  input  logic            mrOtf,
  input  logic [RL_W-1:0] rdLatency,
  output mprStrobe_t      strobe,
  output logic            dqValid,
  output logic            illegalCmd
);

  localparam int BEAT_W = 4;
  localparam logic [BEAT_W-1:0] FULL_BEATS = BEAT_W'(8);
  localparam logic [BEAT_W-1:0] CHOP_BEATS = BEAT_W'(4);

  mprState_t         state;
  logic [RL_W-1:0]   latCnt;
  logic [BEAT_W-1:0] beatsLeft;
  logic              chopQ;
  logic [2:0]        startQ;

  logic              accept;
  logic              chopEff;
  logic              cmdLegal;
  logic [RL_W-1:0]   rlEff;
  logic              latDone;

  // Burst-length selection: per-command request only when permitted
  always_comb begin
    chopEff  = mrOtf ? ~chopReqN : mrChop;
    cmdLegal = dllLocked && (addrLow[1:0] == 2'b00) && !(!chopEff && addrLow[2]);
    accept   = cmdValid && mprEnable && (state == ST_IDLE);
    rlEff    = (rdLatency == '0) ? RL_W'(1) : rdLatency;
    latDone  = (state == ST_WAIT) && (latCnt == RL_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      latCnt     <= '0;
      beatsLeft  <= '0;
      chopQ      <= 1'b0;
      startQ     <= 3'd0;
      illegalCmd <= 1'b0;
    end else begin
      illegalCmd <= accept && !cmdLegal;
      unique case (state)
        ST_IDLE: begin
          if (accept && cmdLegal) begin
            state  <= ST_WAIT;
            latCnt <= rlEff;
            chopQ  <= chopEff;
            startQ <= (chopEff && addrLow[2]) ? 3'd4 : 3'd0;
          end
        end
        ST_WAIT: begin
          if (latDone) begin
            state     <= ST_BURST;
            beatsLeft <= chopQ ? CHOP_BEATS : FULL_BEATS;
          end else begin
            latCnt <= latCnt - RL_W'(1);
          end
        end
        ST_BURST: begin
          if (beatsLeft == BEAT_W'(1)) begin
            state <= ST_IDLE;
          end else begin
            beatsLeft <= beatsLeft - BEAT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load     = latDone;
    strobe.beatEn   = (state == ST_BURST);
    strobe.startIdx = startQ;
    dqValid         = (state == ST_BURST);
  end

endmodule

// File: rtl/mpr_datapath.sv
module mpr_datapath
  import mpr_pkg::*;
#(
  parameter int         LANES   = 2,
  parameter logic [7:0] PATTERN = 8'b0101_0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mprStrobe_t         strobe,
  input  logic               replicateDq,
  output logic [8*LANES-1:0] dq
);

  localparam int LANE_W = 8;

  logic [7:0] shReg;
  logic       serialBit;
  logic [LANE_W-1:0] laneWord;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shReg <= 8'd0;
    end else if (strobe.load) begin
      shReg <= PATTERN >> strobe.startIdx;
    end else if (strobe.beatEn) begin
      shReg <= shReg >> 1;
    end
  end

  always_comb begin
    serialBit = strobe.beatEn && shReg[0];
    laneWord  = {(replicateDq ? {(LANE_W-1){serialBit}} : {(LANE_W-1){1'b0}}), serialBit};
  end

  genvar ln;
  generate
    for (ln = 0; ln < LANES; ln++) begin : g_lane
      assign dq[ln*LANE_W +: LANE_W] = laneWord;
    end
  endgenerate

endmodule

// File: rtl/mpr_read_serializer.sv
module mpr_read_serializer
  import mpr_pkg::*;
#(
  parameter int         LANES   = 2,
  parameter int         ADDR_W  = 13,
  parameter int         BA_W    = 3,
  parameter int         RL_W    = 4,
  parameter logic [7:0] PATTERN = 8'b0101_0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdValid,
  input  logic               mprEnable,
  input  logic               dllLocked,
  input  logic [ADDR_W-1:0]  colAddr,
  input  logic [BA_W-1:0]    bankAddr,
  input  logic               mrChop,
  input  logic               mrOtf,
  input  logic               replicateDq,
  input  logic [RL_W-1:0]    rdLatency,
  output logic [8*LANES-1:0] dq,
  output logic               dqValid,
  output logic               illegalCmd
);

  mprStrobe_t strobe;

  // Bank and middle column bits play no part in a register read
  logic unusedAddrBits;
  assign unusedAddrBits = ^{bankAddr, colAddr[ADDR_W-2:3]};

  mpr_ctrl #(
    .RL_W(RL_W)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmdValid   (cmdValid),
    .mprEnable  (mprEnable),
    .dllLocked  (dllLocked),
    .addrLow    (colAddr[2:0]),
    .chopReqN   (colAddr[ADDR_W-1]),
    .mrChop     (mrChop),
    .mrOtf      (mrOtf),
    .rdLatency  (rdLatency),
    .strobe     (strobe),
    .dqValid    (dqValid),
    .illegalCmd (illegalCmd)
  );

  mpr_datapath #(
    .LANES  (LANES),
    .PATTERN(PATTERN)
  ) dpath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .replicateDq(replicateDq),
    .dq         (dq)
  );

endmodule

// File: rtl/mpr_read_serializer_chk.sv
module mpr_read_serializer_chk #(
  parameter int LANES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmdValid,
  input logic               mprEnable,
  input logic               replicateDq,
  input logic [8*LANES-1:0] dq,
  input logic               dqValid,
  input logic               illegalCmd
);

  logic [3:0] runLen;
  logic       lanesMatch;

  always_ff @(posedge clk) begin
    if (!rst_n)       runLen <= 4'd0;
    else if (dqValid) runLen <= runLen + 4'd1;
    else              runLen <= 4'd0;
  end

  always_comb begin
    lanesMatch = 1'b1;
    for (int l = 1; l < LANES; l++) begin
      if (dq[l*8 +: 8] != dq[7:0]) lanesMatch = 1'b0;
    end
  end

  p_lanes_equal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dqValid |-> lanesMatch);

  p_fill_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dqValid && replicateDq) |-> (dq[7:0] == {8{dq[0]}}));

  p_fill_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dqValid && !replicateDq) |-> (dq[7:1] == 7'd0));

  p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqValid) |-> (runLen == 4'd4 || runLen == 4'd8));

  p_illegal_nodata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegalCmd |-> !dqValid);

  p_illegal_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegalCmd |-> $past(cmdValid && mprEnable));

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dqValid |-> (dq == '0));

endmodule

bind mpr_read_serializer mpr_read_serializer_chk #(.LANES(LANES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmdValid   (cmdValid),
  .mprEnable  (mprEnable),
  .replicateDq(replicateDq),
  .dq         (dq),
  .dqValid    (dqValid),
  .illegalCmd (illegalCmd)
);

// File: tb/mpr_read_serializer_tb_top.sv
module mpr_read_serializer_tb_top;

  localparam int         LANES = 2;
  localparam int         DQ_W  = 8 * LANES;
  localparam logic [7:0] PAT   = 8'b1011_0100;

  typedef struct {
    int              cyc;
    logic [DQ_W-1:0] dq;
    string           tag;
  } beat_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmdValid = 1'b0;
  logic            mprEnable = 1'b1;
  logic            dllLocked = 1'b1;
  logic [12:0]     colAddr = '0;
  logic [2:0]      bankAddr = '0;
  logic            mrChop = 1'b0;
  logic            mrOtf = 1'b0;
  logic            replicateDq = 1'b1;
  logic [3:0]      rdLatency = 4'd3;
  logic [DQ_W-1:0] dq;
  logic            dqValid;
  logic            illegalCmd;

  int    cyc = 0;
  int    nChecks = 0;
  int    nFails = 0;
  bit    finished = 1'b0;
  beat_t sb[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  mpr_read_serializer #(.LANES(LANES), .PATTERN(PAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .mprEnable(mprEnable),
    .dllLocked(dllLocked), .colAddr(colAddr), .bankAddr(bankAddr),
    .mrChop(mrChop), .mrOtf(mrOtf), .replicateDq(replicateDq),
    .rdLatency(rdLatency), .dq(dq), .dqValid(dqValid), .illegalCmd(illegalCmd)
  );

  function automatic logic [DQ_W-1:0] expWord(input logic b, input logic rep);
    logic [7:0] lane;
    lane = rep ? {8{b}} : {7'd0, b};
    return {LANES{lane}};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: issues one command and pushes the expected beats
  task automatic sendCmd(input logic [12:0] a, input logic [2:0] ba,
                         input bit ignored, input string tag);
    bit chop, illegal;
    int start, n, rl, k;
    chop    = mrOtf ? !a[12] : mrChop;
    illegal = !dllLocked || (a[1:0] != 2'b00) || (!chop && a[2]);
    if (ignored || !mprEnable) illegal = 1'b0;
    start = (chop && a[2]) ? 4 : 0;
    n     = chop ? 4 : 8;
    rl    = (rdLatency == 0) ? 1 : int'(rdLatency);
    @(negedge clk);
    cmdValid = 1'b1;
    colAddr  = a;
    bankAddr = ba;
    k = cyc;
    if (!ignored && mprEnable && !illegal) begin
      for (int j = 0; j < n; j++) begin
        beat_t b;
        b.cyc = k + 1 + rl + j;
        b.dq  = expWord(PAT[start + j], replicateDq);
        b.tag = tag;
        sb.push_back(b);
      end
    end
    @(negedge clk);
    cmdValid = 1'b0;
    check(illegalCmd == illegal, tag, "illegalCmd", int'(illegalCmd), int'(illegal));
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops expected beats as the design produces them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (dqValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8/R9", "unexpected beat", int'(dq), 0);
        end else begin
          beat_t e;
          e = sb.pop_front();
          check(cyc == e.cyc, e.tag, "beat cycle", cyc, e.cyc);
          check(dq == e.dq, e.tag, "beat data", int'(dq), int'(e.dq));
        end
      end else begin
        if (sb.size() != 0 && sb[0].cyc < cyc) begin
          beat_t e;
          e = sb.pop_front();
          check(1'b0, e.tag, "missing beat", 0, e.cyc);
        end
        check(dq == '0, "R10", "idle dq", int'(dq), 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dq == '0 && !dqValid && !illegalCmd, "R10", "reset outputs",
          int'({dq, dqValid, illegalCmd}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R1 R2 R7: full burst, replicate
    sendCmd(13'h1000, 3'd0, 0, "R3");
    drain();
    // R2: zero fill
    replicateDq = 1'b0;
    sendCmd(13'h1000, 3'd0, 0, "R2");
    drain();
    replicateDq = 1'b1;

    // R4 R5: fixed chop from mode register, both nibbles; A12 ignored when mrOtf=0
    mrChop = 1'b1;
    sendCmd(13'h1000, 3'd0, 0, "R4");
    drain();
    sendCmd(13'h1004, 3'd0, 0, "R4");
    drain();
    // R5: mrOtf=0, mrChop=0, A12 low still gives a full burst
    mrChop = 1'b0;
    sendCmd(13'h0000, 3'd0, 0, "R5");
    drain();

    // R5: per-command chop
    mrOtf = 1'b1;
    sendCmd(13'h0004, 3'd0, 0, "R5");
    drain();
    sendCmd(13'h1000, 3'd0, 0, "R5");
    drain();
    mrOtf = 1'b0;

    // R6: bank and middle column bits all set
    sendCmd(13'h0FF8, 3'd7, 0, "R6");
    drain();
    mrChop = 1'b1;
    sendCmd(13'h0FFC, 3'd5, 0, "R6");
    drain();
    mrChop = 1'b0;

    // R7: latency extremes
    rdLatency = 4'd0;
    sendCmd(13'h1000, 3'd0, 0, "R7");
    drain();
    rdLatency = 4'd15;
    sendCmd(13'h1000, 3'd0, 0, "R7");
    drain();
    rdLatency = 4'd3;

    // R8: illegal commands
    sendCmd(13'h1001, 3'd0, 0, "R8");
    drain();
    sendCmd(13'h1002, 3'd0, 0, "R8");
    drain();
    sendCmd(13'h1004, 3'd0, 0, "R8");
    drain();
    dllLocked = 1'b0;
    sendCmd(13'h1000, 3'd0, 0, "R8");
    drain();
    dllLocked = 1'b1;

    // R9: mode off, then a command while a read is in flight
    mprEnable = 1'b0;
    sendCmd(13'h1001, 3'd0, 0, "R9");
    drain();
    mprEnable = 1'b1;
    sendCmd(13'h1000, 3'd0, 0, "R9");
    sendCmd(13'h1001, 3'd0, 1, "R9");
    drain();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule